// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits beside a processor core's fetch and register logic. It decides which pending exception is taken and computes every state change that exception entry needs. Seven request pulses are latched as pending: reset, undefined instruction, supervisor call, prefetch abort, data abort, IRQ and FIQ. Each cycle the block picks the highest-priority request that is eligible. It then produces the new status word, the status to save, the return link value and the vector address. It also holds the banked saved-status and link registers of the five exception modes, and it writes the chosen mode's bank on entry.

The core presents its current status word and a PC value every cycle. For aborts, undefined instructions and supervisor calls, the PC is the address of the faulting instruction. For IRQ and FIQ, it is the address of the next instruction. The core applies the entry results one cycle later. An exception-return command reads the bank of the mode named in the current status word and returns the saved status and the return address. Fetching from the vector table and running the handler are left to the core.

Top module: `exc_ctrl`

## Requirements
- R1: The vector address is a base plus four times the slot number. The base is 0xFFFF0000 when `hivec` is high and 0x00000000 otherwise. The slots are reset 0, undefined 1, supervisor call 2, prefetch abort 3, data abort 4, IRQ 6 and FIQ 7. Slot 5 is never produced. `ent_kind` carries the slot number.
- R2: At most one exception is taken per cycle. Priority from highest to lowest is reset, data abort, FIQ, IRQ, prefetch abort, undefined, supervisor call. Requests that lose stay pending until they are taken.
- R3: An IRQ is eligible only while status bit 7 is clear. An FIQ is eligible only while status bit 6 is clear. A masked request stays pending and is taken once its mask bit clears.
- R4: The new status keeps bits 31:8 and sets bit 7. Bit 6 is set for reset and FIQ and kept for the other kinds. Bit 5 is cleared. Bits 4:0 take the target mode code: FIQ 0x11, IRQ 0x12, supervisor 0x13 (reset and supervisor call), abort 0x17 (both aborts) and undefined 0x1B.
- R5: The saved status output equals the status word presented in the cycle the exception was taken. The same value is stored in the target mode's bank.
- R6: The link value is PC+8 for a data abort, 0 for reset and PC+4 for all other kinds. It is stored in the target mode's bank.
- R7: Entry results appear with `ent_valid` high during the cycle after the one in which the request was taken. `ent_valid` lasts one cycle per exception.
- R8: A return command produces `ret_valid` one cycle later. `ret_psr` and `ret_pc` then hold the saved status and link from the bank of the mode in status bits 4:0.
- R9: A return command is ignored, with `ret_valid` held low, when status bits 4:0 name a mode with no bank (user 0x10, system 0x1F, or any other code). It is also ignored in a cycle in which an exception is taken.
- R10: A synchronous reset clears all pending requests and both valid outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset exception request pulse |
| req_undef | input | 1 | Undefined instruction request pulse |
| req_svc | input | 1 | Supervisor call request pulse |
| req_pabt | input | 1 | Prefetch abort request pulse |
| req_dabt | input | 1 | Data abort request pulse |
| req_irq | input | 1 | IRQ request pulse |
| req_fiq | input | 1 | FIQ request pulse |
| hivec | input | 1 | Selects the high vector base |
| cur_pc | input | 32 | PC value used to form the link |
| cur_psr | input | 32 | Current status word |
| eret | input | 1 | Exception-return command |
| ent_valid | output | 1 | Entry results valid |
| ent_kind | output | 3 | Slot number of the taken exception |
| ent_psr | output | 32 | New status word |
| ent_spsr | output | 32 | Status saved into the target bank |
| ent_link | output | 32 | Link value saved into the target bank |
| ent_vector | output | 32 | Vector address |
| ret_valid | output | 1 | Return results valid |
| ret_psr | output | 32 | Status to restore |
| ret_pc | output | 32 | PC to restore |

## Verification
The bench fires all seven requests at once and checks that they drain in priority order, one per cycle. A design with a wrong priority, or one that drops the losing requests, would show a different slot sequence or too few entries. It holds an IRQ and an FIQ behind their mask bits for several cycles and then clears the masks. A design that lost masked requests would never take them, and one that ignored the masks would take them early. Return commands are issued in modes without a bank and in the same cycle as an entry, where a wrong design would raise `ret_valid`. Random traffic also checks that the data-abort link is PC+8, and that the FIQ mask changes only for reset and FIQ entry.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XW     = 32;
    localparam int NSLOT  = 8;
    localparam int NPRIO  = 7;
    localparam int NBANK  = 5;
    localparam int BIDX_W = $clog2(NBANK);

    localparam int PSR_T = 5;
    localparam int PSR_F = 6;
    localparam int PSR_I = 7;

    localparam logic [4:0] MODE_USR = 5'h10;
    localparam logic [4:0] MODE_FIQ = 5'h11;
    localparam logic [4:0] MODE_IRQ = 5'h12;
    localparam logic [4:0] MODE_SVC = 5'h13;
    localparam logic [4:0] MODE_ABT = 5'h17;
    localparam logic [4:0] MODE_UND = 5'h1B;
    localparam logic [4:0] MODE_SYS = 5'h1F;

    typedef enum logic [2:0] {
        EX_RESET = 3'd0,
        EX_UNDEF = 3'd1,
        EX_SVC   = 3'd2,
        EX_PABT  = 3'd3,
        EX_DABT  = 3'd4,
        EX_RSVD  = 3'd5,
        EX_IRQ   = 3'd6,
        EX_FIQ   = 3'd7
    } exc_kind_e;

    typedef struct packed {
        logic [XW-1:0] psr;
        logic [XW-1:0] spsr;
        logic [XW-1:0] link;
        logic [XW-1:0] vector;
    } entry_t;

    typedef struct packed {
        logic              hit;
        logic [BIDX_W-1:0] idx;
    } bank_sel_t;

    // Priority rank 0 is served first.
    function automatic exc_kind_e prio_at(input int rank);
        case (rank)
            0:       return EX_RESET;
            1:       return EX_DABT;
            2:       return EX_FIQ;
            3:       return EX_IRQ;
            4:       return EX_PABT;
            5:       return EX_UNDEF;
            default: return EX_SVC;
        endcase
    endfunction

    function automatic logic [4:0] target_mode(input exc_kind_e k);
        case (k)
            EX_FIQ:           return MODE_FIQ;
            EX_IRQ:           return MODE_IRQ;
            EX_PABT, EX_DABT: return MODE_ABT;
            EX_UNDEF:         return MODE_UND;
            default:          return MODE_SVC;
        endcase
    endfunction

    function automatic bank_sel_t bank_of_mode(input logic [4:0] m);
        bank_sel_t s;
        s.hit = 1'b1;
        case (m)
            MODE_FIQ: s.idx = BIDX_W'(0);
            MODE_IRQ: s.idx = BIDX_W'(1);
            MODE_SVC: s.idx = BIDX_W'(2);
            MODE_ABT: s.idx = BIDX_W'(3);
            MODE_UND: s.idx = BIDX_W'(4);
            default: begin
                s.hit = 1'b0;
                s.idx = '0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] req,
    input  logic             irq_mask,
    input  logic             fiq_mask,
    output logic             grant_vld,
    output exc_kind_e        grant_kind
);

    logic [NSLOT-1:0] pend_q;
    logic [NSLOT-1:0] eff;
    logic [NSLOT-1:0] elig;
    logic [NSLOT-1:0] grant_oh;

    always_comb begin
        eff = pend_q | req;
        eff[EX_RSVD] = 1'b0;
        elig = eff;
        if (irq_mask) elig[EX_IRQ] = 1'b0;
        if (fiq_mask) elig[EX_FIQ] = 1'b0;
    end

    always_comb begin
        grant_vld  = 1'b0;
        grant_kind = EX_RESET;
        for (int r = 0; r < NPRIO; r++) begin
            if (!grant_vld && elig[prio_at(r)]) begin
                grant_vld  = 1'b1;
                grant_kind = prio_at(r);
            end
        end
        grant_oh = '0;
        if (grant_vld) grant_oh[grant_kind] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= eff & ~grant_oh;
    end

    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_oh));

    a_r3_irq_respects_mask: assert property (@(posedge clk) disable iff (rst)
        (grant_vld && grant_kind == EX_IRQ) |-> !irq_mask);

    a_r3_fiq_respects_mask: assert property (@(posedge clk) disable iff (rst)
        (grant_vld && grant_kind == EX_FIQ) |-> !fiq_mask);

    a_r3_masked_irq_kept: assert property (@(posedge clk) disable iff (rst)
        (eff[EX_IRQ] && !grant_oh[EX_IRQ]) |=> pend_q[EX_IRQ]);

    a_r2_loser_kept: assert property (@(posedge clk) disable iff (rst)
        (eff[EX_SVC] && !grant_oh[EX_SVC]) |=> pend_q[EX_SVC]);

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
    import exc_pkg::*;
#(
    parameter logic [XW-1:0] HI_BASE = 32'hFFFF_0000,
    parameter logic [XW-1:0] LO_BASE = 32'h0000_0000
) (
    input  exc_kind_e     kind,
    input  logic [XW-1:0] cur_psr,
    input  logic [XW-1:0] cur_pc,
    input  logic          hivec,
    output entry_t        ent
);

    always_comb begin
        ent.spsr = cur_psr;

        ent.psr        = cur_psr;
        ent.psr[4:0]   = target_mode(kind);
        ent.psr[PSR_T] = 1'b0;
        ent.psr[PSR_I] = 1'b1;
        if (kind == EX_FIQ || kind == EX_RESET) ent.psr[PSR_F] = 1'b1;

        case (kind)
            EX_RESET: ent.link = '0;
            EX_DABT:  ent.link = cur_pc + XW'(8);
            default:  ent.link = cur_pc + XW'(4);
        endcase

        ent.vector = (hivec ? HI_BASE : LO_BASE) + {{(XW-5){1'b0}}, kind, 2'b00};
    end

endmodule

// File: rtl/exc_bank.sv
module exc_bank
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BIDX_W-1:0] wr_idx,
    input  logic [XW-1:0]     wr_psr,
    input  logic [XW-1:0]     wr_link,
    input  logic [BIDX_W-1:0] rd_idx,
    output logic [XW-1:0]     rd_psr,
    output logic [XW-1:0]     rd_link
);

    logic [XW-1:0] psr_q  [NBANK];
    logic [XW-1:0] link_q [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                psr_q[g]  <= '0;
                link_q[g] <= '0;
            end else if (wr_en && wr_idx == BIDX_W'(g)) begin
                psr_q[g]  <= wr_psr;
                link_q[g] <= wr_link;
            end
        end
    end

    always_comb begin
        rd_psr  = '0;
        rd_link = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (rd_idx == BIDX_W'(b)) begin
                rd_psr  = psr_q[b];
                rd_link = link_q[b];
            end
        end
    end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_reset,
    input  logic        req_undef,
    input  logic        req_svc,
    input  logic        req_pabt,
    input  logic        req_dabt,
    input  logic        req_irq,
    input  logic        req_fiq,
    input  logic        hivec,
    input  logic [31:0] cur_pc,
    input  logic [31:0] cur_psr,
    input  logic        eret,
    output logic        ent_valid,
    output logic [2:0]  ent_kind,
    output logic [31:0] ent_psr,
    output logic [31:0] ent_spsr,
    output logic [31:0] ent_link,
    output logic [31:0] ent_vector,
    output logic        ret_valid,
    output logic [31:0] ret_psr,
    output logic [31:0] ret_pc
);

    logic [NSLOT-1:0] req_vec;
    logic             grant_vld;
    exc_kind_e        grant_kind;
    entry_t           ent_d;
    entry_t           ent_q;
    exc_kind_e        kind_q;
    bank_sel_t        wr_sel;
    bank_sel_t        rd_sel;
    logic [XW-1:0]    bank_psr;
    logic [XW-1:0]    bank_link;
    logic             ret_take;

    always_comb begin
        req_vec           = '0;
        req_vec[EX_RESET] = req_reset;
        req_vec[EX_UNDEF] = req_undef;
        req_vec[EX_SVC]   = req_svc;
        req_vec[EX_PABT]  = req_pabt;
        req_vec[EX_DABT]  = req_dabt;
        req_vec[EX_IRQ]   = req_irq;
        req_vec[EX_FIQ]   = req_fiq;
    end

    exc_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .req        (req_vec),
        .irq_mask   (cur_psr[PSR_I]),
        .fiq_mask   (cur_psr[PSR_F]),
        .grant_vld  (grant_vld),
        .grant_kind (grant_kind)
    );

    exc_entry_calc u_calc (
        .kind    (grant_kind),
        .cur_psr (cur_psr),
        .cur_pc  (cur_pc),
        .hivec   (hivec),
        .ent     (ent_d)
    );

    assign wr_sel   = bank_of_mode(target_mode(grant_kind));
    assign rd_sel   = bank_of_mode(cur_psr[4:0]);
    assign ret_take = eret && rd_sel.hit && !grant_vld;

    exc_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (grant_vld),
        .wr_idx  (wr_sel.idx),
        .wr_psr  (ent_d.spsr),
        .wr_link (ent_d.link),
        .rd_idx  (rd_sel.idx),
        .rd_psr  (bank_psr),
        .rd_link (bank_link)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= 1'b0;
            ret_valid <= 1'b0;
            ent_q     <= '0;
            kind_q    <= EX_RESET;
            ret_psr   <= '0;
            ret_pc    <= '0;
        end else begin
            ent_valid <= grant_vld;
            ret_valid <= ret_take;
            if (grant_vld) begin
                ent_q  <= ent_d;
                kind_q <= grant_kind;
            end
            if (ret_take) begin
                ret_psr <= bank_psr;
                ret_pc  <= bank_link;
            end
        end
    end

    assign ent_kind   = kind_q;
    assign ent_psr    = ent_q.psr;
    assign ent_spsr   = ent_q.spsr;
    assign ent_link   = ent_q.link;
    assign ent_vector = ent_q.vector;

    a_r9_entry_or_return: assert property (@(posedge clk) disable iff (rst)
        !(ent_valid && ret_valid));

    a_r4_entry_state: assert property (@(posedge clk) disable iff (rst)
        ent_valid |-> (ent_psr[PSR_I] && !ent_psr[PSR_T]));

    a_r5_saved_status: assert property (@(posedge clk) disable iff (rst)
        ent_valid |-> ent_spsr == $past(cur_psr));

    a_r1_vector_base: assert property (@(posedge clk) disable iff (rst)
        ent_valid |-> ent_vector[31:16] == ($past(hivec) ? 16'hFFFF : 16'h0000));

    a_r1_no_reserved_slot: assert property (@(posedge clk) disable iff (rst)
        ent_valid |-> ent_kind != 3'd5);

    a_r9_no_return_unbanked: assert property (@(posedge clk) disable iff (rst)
        (eret && (cur_psr[4:0] == MODE_USR || cur_psr[4:0] == MODE_SYS)) |=> !ret_valid);

endmodule

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_reset = 0, req_undef = 0, req_svc = 0, req_pabt = 0;
    logic        req_dabt = 0, req_irq = 0, req_fiq = 0;
    logic        hivec = 0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_psr = 32'h10;
    logic        eret = 0;
    logic        ent_valid;
    logic [2:0]  ent_kind;
    logic [31:0] ent_psr, ent_spsr, ent_link, ent_vector;
    logic        ret_valid;
    logic [31:0] ret_psr, ret_pc;

    int n_tests = 0;
    int n_fail  = 0;

    // reference state
    logic [7:0]  m_pend;
    logic [31:0] m_bpsr [5];
    logic [31:0] m_blnk [5];

    // expectations for the next edge
    logic        x_ent_v;
    logic [2:0]  x_kind;
    logic [31:0] x_psr, x_spsr, x_link, x_vec;
    logic        x_ret_v;
    logic [31:0] x_rpsr, x_rpc;

    always #2 clk = ~clk;

    exc_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_reset(req_reset), .req_undef(req_undef), .req_svc(req_svc),
        .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
        .hivec(hivec), .cur_pc(cur_pc), .cur_psr(cur_psr), .eret(eret),
        .ent_valid(ent_valid), .ent_kind(ent_kind), .ent_psr(ent_psr),
        .ent_spsr(ent_spsr), .ent_link(ent_link), .ent_vector(ent_vector),
        .ret_valid(ret_valid), .ret_psr(ret_psr), .ret_pc(ret_pc)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int bank_idx(input logic [4:0] m);
        case (m)
            5'h11: return 0;
            5'h12: return 1;
            5'h13: return 2;
            5'h17: return 3;
            5'h1B: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [4:0] mode_for(input int k);
        case (k)
            7: return 5'h11;
            6: return 5'h12;
            3, 4: return 5'h17;
            1: return 5'h1B;
            default: return 5'h13;
        endcase
    endfunction

    function automatic int rank_kind(input int r);
        int order [7] = '{0, 4, 7, 6, 3, 1, 2};
        return order[r];
    endfunction

    // Called at a negedge; drives inputs, predicts, advances to next sample point.
    task automatic step(input logic [7:0] r, input logic [31:0] psr, input logic [31:0] pc,
                        input logic hv, input logic er);
        logic [7:0] eff;
        int k;
        int wb;
        int rb;
        req_reset = r[0]; req_undef = r[1]; req_svc = r[2]; req_pabt = r[3];
        req_dabt = r[4]; req_irq = r[6]; req_fiq = r[7];
        cur_psr = psr; cur_pc = pc; hivec = hv; eret = er;

        eff = m_pend | r;
        eff[5] = 1'b0;
        k = -1;
        for (int i = 0; i < 7; i++) begin
            int c = rank_kind(i);
            if (k < 0 && eff[c] && !(c == 6 && psr[7]) && !(c == 7 && psr[6])) k = c;
        end
        x_ent_v = (k >= 0);
        x_ret_v = 1'b0;
        if (k >= 0) begin
            x_kind = 3'(k);
            x_spsr = psr;
            x_psr  = psr;
            x_psr[4:0] = mode_for(k);
            x_psr[5] = 1'b0;
            x_psr[7] = 1'b1;
            if (k == 0 || k == 7) x_psr[6] = 1'b1;
            x_link = (k == 0) ? 32'h0 : (k == 4) ? pc + 32'd8 : pc + 32'd4;
            x_vec  = (hv ? 32'hFFFF_0000 : 32'h0) + 32'(k * 4);
            eff[k] = 1'b0;
        end else begin
            rb = bank_idx(psr[4:0]);
            if (er && rb >= 0) begin
                x_ret_v = 1'b1;
                x_rpsr  = m_bpsr[rb];
                x_rpc   = m_blnk[rb];
            end
        end
        m_pend = eff;
        if (k >= 0) begin
            wb = bank_idx(mode_for(k));
            m_bpsr[wb] = x_spsr;
            m_blnk[wb] = x_link;
        end

        @(posedge clk);
        #1;
        chk("R7 ent_valid", 32'(ent_valid), 32'(x_ent_v));
        if (x_ent_v && ent_valid) begin
            chk("R2 ent_kind", 32'(ent_kind), 32'(x_kind));
            chk("R4 ent_psr", ent_psr, x_psr);
            chk("R5 ent_spsr", ent_spsr, x_spsr);
            chk("R6 ent_link", ent_link, x_link);
            chk("R1 ent_vector", ent_vector, x_vec);
        end
        chk("R9 ret_valid", 32'(ret_valid), 32'(x_ret_v));
        if (x_ret_v && ret_valid) begin
            chk("R8 ret_psr", ret_psr, x_rpsr);
            chk("R8 ret_pc", ret_pc, x_rpc);
        end
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk_psr(input logic [23:0] hi, input logic i, input logic f,
                                           input logic t, input logic [4:0] m);
        return {hi, i, f, t, m};
    endfunction

    initial begin
        int dummy;
        logic [4:0] modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
        dummy = $urandom(32'd1357);
        m_pend = '0;
        for (int b = 0; b < 5; b++) begin m_bpsr[b] = '0; m_blnk[b] = '0; end

        repeat (3) @(posedge clk);
        #1;
        chk("R10 ent_valid after reset", 32'(ent_valid), 32'd0);
        chk("R10 ret_valid after reset", 32'(ret_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // each kind alone, both vector bases
        for (int hv = 0; hv < 2; hv++) begin
            for (int k = 0; k < 8; k++) begin
                if (k != 5)
                    step(8'(1 << k), mk_psr(24'hA5A5A5, 0, 0, 1, 5'h10),
                         32'h0000_1000 + 32'(k * 16), hv[0], 1'b0);
            end
        end

        // all at once: drains in priority order (R2)
        step(8'hDF, mk_psr(24'h000001, 0, 0, 0, 5'h10), 32'h2000, 1'b0, 1'b0);
        chk("R2 first is reset", 32'(ent_kind), 32'd0);
        for (int i = 1; i < 7; i++) begin
            step(8'h00, mk_psr(24'h000001, 0, 0, 0, 5'h10), 32'h2000 + 32'(i * 4), 1'b0, 1'b0);
            chk("R2 drain order", 32'(ent_kind), 32'(rank_kind(i)));
        end
        step(8'h00, mk_psr(24'h0, 0, 0, 0, 5'h10), 32'h0, 1'b0, 1'b0);
        chk("R2 nothing left", 32'(ent_valid), 32'd0);

        // masked IRQ and FIQ stay pending (R3)
        step(8'hC0, mk_psr(24'h0, 1, 1, 0, 5'h10), 32'h3000, 1'b0, 1'b0);
        chk("R3 masked not taken", 32'(ent_valid), 32'd0);
        for (int i = 0; i < 3; i++) begin
            step(8'h00, mk_psr(24'h0, 1, 1, 0, 5'h10), 32'h3000, 1'b0, 1'b0);
            chk("R3 still masked", 32'(ent_valid), 32'd0);
        end
        step(8'h00, mk_psr(24'h0, 0, 1, 0, 5'h10), 32'h3100, 1'b0, 1'b0);
        chk("R3 irq after unmask", 32'(ent_kind), 32'd6);
        step(8'h00, mk_psr(24'h0, 1, 0, 0, 5'h12), 32'h3200, 1'b0, 1'b0);
        chk("R3 fiq after unmask", 32'(ent_kind), 32'd7);

        // returns: banked mode, unbanked modes, collision with entry
        step(8'h00, mk_psr(24'h0, 1, 1, 0, 5'h11), 32'h0, 1'b0, 1'b1);
        chk("R8 fiq return pc", ret_pc, 32'h3204);
        step(8'h00, mk_psr(24'h0, 1, 0, 0, 5'h12), 32'h0, 1'b0, 1'b1);
        chk("R8 irq return pc", ret_pc, 32'h3104);
        step(8'h00, mk_psr(24'h0, 0, 0, 0, 5'h10), 32'h0, 1'b0, 1'b1);
        chk("R9 user mode return ignored", 32'(ret_valid), 32'd0);
        step(8'h00, mk_psr(24'h0, 0, 0, 0, 5'h1F), 32'h0, 1'b0, 1'b1);
        chk("R9 system mode return ignored", 32'(ret_valid), 32'd0);
        step(8'h04, mk_psr(24'h0, 0, 0, 0, 5'h13), 32'h4000, 1'b0, 1'b1);
        chk("R9 return dropped on entry", 32'(ret_valid), 32'd0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] r;
            logic [31:0] p;
            r = '0;
            for (int b = 1; b < 8; b++) if (b != 5 && ($urandom % 10) == 0) r[b] = 1'b1;
            if (($urandom % 60) == 0) r[0] = 1'b1;
            p = $urandom;
            p[4:0] = modes[$urandom % 7];
            step(r, p, $urandom, 1'($urandom), (($urandom % 3) == 0));
        end

        // synchronous reset clears pending (R10)
        step(8'h40, mk_psr(24'h0, 1, 0, 0, 5'h10), 32'h0, 1'b0, 1'b0);
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R10 ent_valid in reset", 32'(ent_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        m_pend = '0;
        for (int b = 0; b < 5; b++) begin m_bpsr[b] = '0; m_blnk[b] = '0; end
        step(8'h00, mk_psr(24'h0, 0, 0, 0, 5'h10), 32'h0, 1'b0, 1'b0);
        chk("R10 pending cleared", 32'(ent_valid), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule